// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block runs an external single-slope converter front end. It provides a 3-bit channel address and a ramp-start output, and it takes in the comparator's ramp-stop signal. When a conversion is requested, the sequencer puts the channel address on the bus and holds ramp-start low for a programmable number of cycles. During that time the front end samples the selected input onto its ramp capacitor. The sequencer then raises ramp-start and counts clock cycles until ramp-stop falls. It reports the saturated count together with the channel number.

The block can convert a single channel. It can also run a scan that visits every address in ascending order: the ground slot, the six analog inputs, and the full-scale reference slot. A downstream block can then apply zero and gain correction to the counts. If the comparator never falls, a programmable cycle limit ends the conversion and marks the result as an error.

Top module: `ssadc_seq`

## Requirements
- R1: While rst_n is low and right after it is released, busy, ramp_go and res_valid are 0 and ch_addr is 000.
- R2: A start pulse accepted while idle puts the target address on ch_addr (chan_sel when mode_scan is 0). ramp_go then stays low for exactly the configured acquisition length in cycles, counted from the first cycle busy is high, and then rises. ch_addr does not change while ramp_go is low.
- R3: If ramp_stop is low and stable before the k-th rising clock edge after ramp_go rises, the reported count is k+1. A ground-slot conversion also ends only on this falling edge.
- R4: The count saturates at 255 (all ones of the 8-bit result) when the ramp lasts longer than that.
- R5: With timeout limit T, if no fall has ended the conversion by the T-th rising edge after ramp_go rises, a result is issued at that edge with res_err=1 and count min(T-1,255). A fall that lands on that same edge wins, and res_err stays 0.
- R6: Each conversion yields exactly one single-cycle res_valid pulse. In that cycle, res_chan holds the address that was converted, res_err is valid, and ramp_go is already low.
- R7: With mode_scan=1, addresses 000 (ground), 001 to 110 (inputs 1 to 6) and 111 (full-scale reference) are converted in increasing order with one result each. After the last one the block returns to idle.
- R8: A start pulse while busy is ignored. No extra result appears and no address changes.
- R9: A configuration write while idle stores an acquisition length of at least 4 and a timeout limit of at least 1; smaller values are raised to these minimums. Writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_acq | input | 8 | Acquisition length in cycles |
| cfg_tmo | input | 12 | Ramp timeout limit in cycles |
| start | input | 1 | Conversion request |
| mode_scan | input | 1 | 1 = scan all eight addresses, 0 = single channel |
| chan_sel | input | 3 | Channel for a single conversion |
| busy | output | 1 | Sequence in progress |
| ch_addr | output | 3 | Channel address to the front end |
| ramp_go | output | 1 | Ramp-start: low = acquire, high = ramp |
| ramp_stop | input | 1 | Comparator output, asynchronous |
| res_valid | output | 1 | One-cycle result strobe |
| res_count | output | 8 | Ramp count, saturated |
| res_chan | output | 3 | Channel tag of the result |
| res_err | output | 1 | Conversion ended by timeout |

## Verification
An acquisition counter in the wrong state shows up at the first rising edge of ramp_go, as a low phase that is too short or too long. A timer or synchronizer fault shows up in the very next result word as a count that is off by a fixed amount or has the wrong error flag. A fault in the scan pointer or mode register shows up within one result, as a wrong or repeated channel tag or as a missing or extra result before busy drops.

// File: rtl/ssadc_pkg.sv
// Shared types for the single-slope conversion sequencer.
// Assumes a 3-bit address map with ground at all zeros and reference at all ones.
package ssadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_RAMP = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ssadc_fall_det.sv
// Synchronizes the asynchronous comparator output and flags its falling edge.
// Assumes the pin idles high (pull-up), so the chain resets to ones.
module ssadc_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES:0] sh;

    // Shift chain: STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/ssadc_ramp_timer.sv
// Counts ramp cycles, gives a saturated result and a timeout flag.
// Assumes TMO_W >= CNT_W and tmo_lim >= 1.
module ssadc_ramp_timer #(
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    logic [TMO_W-1:0] rcyc;

    // Cycle counter: cleared outside the ramp, saturating inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  rcyc <= '0;
        else if (rcyc != '1) rcyc <= rcyc + 1'b1;
    end

    generate
        if (TMO_W > CNT_W) begin : g_sat
            assign count = (|rcyc[TMO_W-1:CNT_W]) ? '1 : rcyc[CNT_W-1:0];
        end else begin : g_direct
            assign count = rcyc[CNT_W-1:0];
        end
    endgenerate

    assign expired = (rcyc == tmo_lim - 1'b1);
endmodule

// File: rtl/ssadc_cfg.sv
// Holds acquisition length and timeout limit, raising each to its minimum on write.
// Assumes the caller blocks writes while a sequence runs.
module ssadc_cfg #(
    parameter int ACQ_W   = 8,
    parameter int ACQ_MIN = 4,
    parameter int ACQ_DEF = 16,
    parameter int TMO_W   = 12,
    parameter int TMO_DEF = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ACQ_W-1:0] acq_in,
    input  logic [TMO_W-1:0] tmo_in,
    output logic [ACQ_W-1:0] acq_len,
    output logic [TMO_W-1:0] tmo_lim
);
    localparam logic [ACQ_W-1:0] ACQ_FLOOR = ACQ_W'(ACQ_MIN);
    localparam logic [TMO_W-1:0] TMO_FLOOR = TMO_W'(1);

    // Configuration registers with minimum enforcement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_len <= ACQ_W'(ACQ_DEF);
            tmo_lim <= TMO_W'(TMO_DEF);
        end else if (we) begin
            acq_len <= (acq_in < ACQ_FLOOR) ? ACQ_FLOOR : acq_in;
            tmo_lim <= (tmo_in < TMO_FLOOR) ? TMO_FLOOR : tmo_in;
        end
    end
endmodule

// File: rtl/ssadc_seq.sv
// Sequencer for an external single-slope converter: acquisition, ramp timing, scan.
// Assumes ramp_stop is high while the capacitor holds charge and falls at ramp end.
module ssadc_seq #(
    parameter int ACQ_W       = 8,
    parameter int ACQ_MIN     = 4,
    parameter int ACQ_DEF     = 16,
    parameter int TMO_W       = 12,
    parameter int TMO_DEF     = 400,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [ACQ_W-1:0] cfg_acq,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             start,
    input  logic             mode_scan,
    input  logic [2:0]       chan_sel,
    output logic             busy,
    output logic [2:0]       ch_addr,
    output logic             ramp_go,
    input  logic             ramp_stop,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_count,
    output logic [2:0]       res_chan,
    output logic             res_err
);
    import ssadc_pkg::*;

    localparam logic [2:0] ADDR_LAST = 3'b111;

    seq_state_t       state;
    logic             scan_q;
    logic [ACQ_W-1:0] acq_cnt;
    logic [ACQ_W-1:0] acq_len;
    logic [TMO_W-1:0] tmo_lim;
    logic [CNT_W-1:0] t_count;
    logic             t_expired;
    logic             stop_fall;
    logic             ramp_end;

    assign busy     = (state != ST_IDLE);
    assign ramp_go  = (state == ST_RAMP);
    assign ramp_end = ramp_go && (stop_fall || t_expired);

    ssadc_cfg #(
        .ACQ_W(ACQ_W), .ACQ_MIN(ACQ_MIN), .ACQ_DEF(ACQ_DEF),
        .TMO_W(TMO_W), .TMO_DEF(TMO_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && !busy),
        .acq_in(cfg_acq), .tmo_in(cfg_tmo),
        .acq_len(acq_len), .tmo_lim(tmo_lim)
    );

    ssadc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk(clk), .rst_n(rst_n), .din(ramp_stop), .fall(stop_fall)
    );

    ssadc_ramp_timer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(ramp_go), .tmo_lim(tmo_lim),
        .count(t_count), .expired(t_expired)
    );

    // Phase sequencing, channel stepping and acquisition counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scan_q  <= 1'b0;
            ch_addr <= '0;
            acq_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_ACQ;
                    scan_q  <= mode_scan;
                    ch_addr <= mode_scan ? 3'b000 : chan_sel;
                    acq_cnt <= '0;
                end
                ST_ACQ: begin
                    if (acq_cnt == acq_len - 1'b1) state <= ST_RAMP;
                    else                           acq_cnt <= acq_cnt + 1'b1;
                end
                ST_RAMP: if (ramp_end) begin
                    if (scan_q && ch_addr != ADDR_LAST) begin
                        state   <= ST_ACQ;
                        ch_addr <= ch_addr + 3'd1;
                        acq_cnt <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result word capture and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_count <= '0;
            res_chan  <= '0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= ramp_end;
            if (ramp_end) begin
                res_count <= t_count;
                res_chan  <= ch_addr;
                res_err   <= !stop_fall;
            end
        end
    end
endmodule

// File: rtl/ssadc_seq_chk.sv
// Port-level protocol checks for ssadc_seq, attached by bind.
module ssadc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       ramp_go,
    input logic [2:0] ch_addr,
    input logic       res_valid,
    input logic [2:0] res_chan
);
    a_r1_ramp_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_go |-> busy);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ramp_go && $past(busy && !ramp_go)) |-> $stable(ch_addr));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_ramp_low_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !ramp_go);

    a_r6_tag_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan == $past(ch_addr)));

    a_r7_scan_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && busy) |-> (ch_addr == 3'(res_chan + 3'd1)));
endmodule

bind ssadc_seq ssadc_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ramp_go(ramp_go),
    .ch_addr(ch_addr), .res_valid(res_valid), .res_chan(res_chan)
);

// File: tb/sim_ssadc_seq.sv
module sim_ssadc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_acq = '0;
    logic [11:0] cfg_tmo = '0;
    logic        start = 1'b0;
    logic        mode_scan = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic        busy, ramp_go, res_valid, res_err;
    logic [2:0]  ch_addr, res_chan;
    logic [7:0]  res_count;
    logic        ramp_stop = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int dly[8];
    int tmo_cur = 400;
    int exp_acq = 16;

    typedef struct {
        int    ch;
        int    cnt;
        bit    err;
        string req;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    ssadc_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_acq(cfg_acq),
        .cfg_tmo(cfg_tmo), .start(start), .mode_scan(mode_scan),
        .chan_sel(chan_sel), .busy(busy), .ch_addr(ch_addr),
        .ramp_go(ramp_go), .ramp_stop(ramp_stop), .res_valid(res_valid),
        .res_count(res_count), .res_chan(res_chan), .res_err(res_err)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Expected result from the count and timeout rules (R3, R4, R5).
    function automatic item_t mk(int ch, string req);
        item_t it;
        int n;
        n = dly[ch];
        it.ch = ch;
        it.req = req;
        if (n < 0 || tmo_cur < n + 3) begin
            it.err = 1;
            it.cnt = (tmo_cur - 1 > 255) ? 255 : tmo_cur - 1;
        end else begin
            it.err = 0;
            it.cnt = (n + 2 > 255) ? 255 : n + 2;
        end
        return it;
    endfunction

    // Comparator model: falls dly[addr] negedges after ramp_go is first seen high.
    initial begin
        int n;
        forever begin
            @(negedge clk);
            if (ramp_go) begin
                n = dly[ch_addr];
                if (n >= 0) begin
                    for (int i = 0; i < n; i++) begin
                        @(negedge clk);
                        if (!ramp_go) break;
                    end
                    if (ramp_go) ramp_stop = 1'b0;
                end
                while (ramp_go) @(negedge clk);
                ramp_stop = 1'b1;
            end
        end
    end

    // Monitor: scoreboard pop on results, acquisition length and address checks.
    initial begin
        int   low_run;
        bit   prev_go;
        logic [2:0] addr0;
        item_t e;
        low_run = 0;
        prev_go = 0;
        addr0 = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    if (q.size() == 0) begin
                        chk(0, "R8 unexpected result", res_chan, -1);
                    end else begin
                        e = q.pop_front();
                        chk(res_chan == 3'(e.ch), {e.req, " chan"}, res_chan, e.ch);
                        chk(res_count == 8'(e.cnt), {e.req, " count"}, res_count, e.cnt);
                        chk(res_err == e.err, {e.req, " err"}, res_err, e.err);
                    end
                end
                if (busy && !ramp_go) begin
                    low_run++;
                    if (low_run == 1) addr0 = ch_addr;
                    else if (ch_addr != addr0) chk(0, "R2 addr moved", ch_addr, addr0);
                end
                if (ramp_go && !prev_go) begin
                    chk(low_run == exp_acq, "R2 acq length", low_run, exp_acq);
                    low_run = 0;
                end
                prev_go = ramp_go;
            end
        end
    end

    task automatic cfg(int acq, int tmo);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_acq = 8'(acq);
        cfg_tmo = 12'(tmo);
        @(negedge clk);
        cfg_we = 1'b0;
        if (!busy) begin
            exp_acq = (acq < 4) ? 4 : acq;
            tmo_cur = (tmo < 1) ? 1 : tmo;
        end
    endtask

    task automatic pulse_start(bit scan, int ch);
        @(negedge clk);
        start = 1'b1;
        mode_scan = scan;
        chan_sel = 3'(ch);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run(bit scan, int ch, string req);
        if (scan) begin
            for (int c = 0; c < 8; c++) q.push_back(mk(c, req));
        end else begin
            q.push_back(mk(ch, req));
        end
        pulse_start(scan, ch);
        wait_idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) dly[i] = 10;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(ramp_go == 0, "R1 ramp_go", ramp_go, 0);
        chk(res_valid == 0, "R1 res_valid", res_valid, 0);
        chk(ch_addr == 0, "R1 ch_addr", ch_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && ramp_go == 0, "R1 after release", busy, 0);

        // R2, R3: single conversions
        cfg(6, 400);
        dly[3] = 10;
        run(0, 3, "R3 single ch3");
        dly[0] = 0;
        run(0, 0, "R3 ground slot");
        dly[5] = 77;
        run(0, 5, "R3 single ch5");

        // R7: full scan with distinct ramp times
        for (int i = 0; i < 8; i++) dly[i] = 5 + i * 20;
        run(1, 0, "R7 scan");
        chk(busy == 0, "R7 idle after scan", busy, 0);

        // R4: saturation
        cfg(6, 1000);
        dly[6] = 300;
        run(0, 6, "R4 saturate");

        // R5: timeouts and boundary
        cfg(5, 100);
        dly[2] = -1;
        run(0, 2, "R5 timeout 100");
        cfg(5, 300);
        run(0, 2, "R5 timeout sat");
        cfg(5, 50);
        dly[4] = 47;
        run(0, 4, "R5 fall wins at limit");
        dly[4] = 48;
        run(0, 4, "R5 timeout by one");

        // R9: minimums enforced
        cfg(1, 0);
        dly[1] = 5;
        run(0, 1, "R9 minimum limits");

        // R9: write while busy ignored
        cfg(8, 400);
        dly[7] = 40;
        q.push_back(mk(7, "R9 first conv"));
        pulse_start(0, 7);
        repeat (5) @(negedge clk);
        cfg(30, 20);
        wait_idle();
        repeat (3) @(negedge clk);
        run(0, 7, "R9 old config kept");

        // R8: start while busy ignored
        dly[3] = 60;
        q.push_back(mk(3, "R8 original"));
        pulse_start(0, 3);
        repeat (10) @(negedge clk);
        pulse_start(1, 5);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R8 no extra result", q.size(), 0);
        chk(busy == 0, "R8 idle", busy, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule